// File: doc/BRIEF.md
# Symmetric Pre-Add FIR Cell

This block is the arithmetic core of an 8-tap FIR filter that relies on coefficient symmetry. Two delay lines carry samples: a forward line fed by the input sample, and a reverse line fed from a pair of last-in first-out buffers. Each of the four lanes adds one forward tap and one reverse tap, multiplies the sum by its coefficient, and the four products are summed at full precision. The result goes to an accumulator stage outside the block. Eight taps therefore cost only four multipliers.

Every shift moves the sample that leaves the far end of the forward line into the LIFO being written. The reverse line pops the other LIFO. A transfer strobe swaps the two buffers. Reading back in reverse order gives the mirrored sample ordering that a symmetric kernel needs. With a decimation factor D from 1 to 16, adjacent taps sit D samples apart, which also gives the row delays used by two-dimensional kernels. Coefficients come from an external bank on every cycle. The decimation factor is a static setting.

Top module: `symfir_cell`

## Requirements
- R1: While reset is low, and after it is released, all delay line and LIFO storage reads as zero. With no shift since reset, `sum_o` is 0 whatever the enables and coefficients are.
- R2: Samples and coefficients are 10-bit two's complement. Coefficient k sits at `coef_i[10k+9:10k]`. With the reverse operand disabled, `sum_o` = sum over k=0..3 of coef k times forward tap k. Forward tap k is the sample shifted in k*D shifts before the newest one. All inputs are registered, so a shift presented in one cycle shows in `sum_o` three rising edges later.
- R3: Each lane forms an 11-bit sum of its forward and reverse operands before it multiplies. The products are 21 bits and `sum_o` is 23 bits with no truncation. For example, all taps at -512 with all coefficients at -512 give 2097152, and with all coefficients at 511 they give -2093056.
- R4: While `shift_n_i` is high, both delay lines and both LIFOs hold, so `sum_o` stays constant if coefficients and enables are unchanged, whatever `smp_i` does.
- R5: While `fwd_n_i` is high, every lane's forward operand is zero. While both `fwd_n_i` and `rev_n_i` are high, `sum_o` is 0.
- R6: While `rev_n_i` is high, every lane's reverse operand is zero. This supports asymmetric filtering.
- R7: The decimation factor is D = `dec_m1_i` + 1, from 1 to 16. Adjacent taps on both lines are D shifts apart.
- R8: On each shift, the sample that leaves the forward line (the one NT*D shifts old, NT = 4) is pushed into the write LIFO. The read LIFO is popped newest first into the reverse line, whose tap k holds the sample popped k*D shifts earlier. A low `xfer_n_i` swaps the roles of the two LIFOs and empties the new write LIFO.
- R9: Popping an empty read LIFO feeds zero into the reverse line. Before the first transfer after reset, the reverse path therefore contributes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_i | input | 10 | Signed input sample |
| coef_i | input | 40 | Four signed coefficients, lane k in bits 10k+9:10k |
| shift_n_i | input | 1 | Active-low shift enable for delay lines and LIFOs |
| fwd_n_i | input | 1 | Active-low forward operand enable |
| rev_n_i | input | 1 | Active-low reverse operand enable |
| xfer_n_i | input | 1 | Active-low LIFO role swap |
| dec_m1_i | input | 4 | Decimation factor minus one (static) |
| sum_o | output | 23 | Signed sum of the four lane products |

## Verification
The embedded properties assume three things about the inputs. `dec_m1_i` changes only while reset is held. A transfer and a shift are not asserted in the same cycle. No more than 64 shifts occur between transfers, so the write LIFO never overflows. The stimulus meets all three: it sets the decimation factor before releasing reset, raises each strobe for a single cycle in its own task call, and issues a transfer within a dozen shifts. Coefficients and enables are held steady through each observation window so that every expected sum depends only on the stored samples.

// File: rtl/symfir_pkg.sv
package symfir_pkg;
    localparam int SMP_W_DEF  = 10;
    localparam int COEF_W_DEF = 10;
    localparam int PAIRS_DEF  = 4;
    localparam int DEC_MAX_DEF = 16;

    typedef struct packed {
        logic shift_n;
        logic fwd_n;
        logic rev_n;
        logic xfer_n;
    } strobe_t;
endpackage

// File: rtl/symfir_dline.sv
module symfir_dline #(
    parameter int W    = 10,
    parameter int NP   = 4,
    parameter int DMAX = 16,
    localparam int LEN = NP * DMAX,
    localparam int IW  = $clog2(LEN),
    localparam int DW  = $clog2(DMAX)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                adv,
    input  logic signed [W-1:0] din,
    input  logic [DW-1:0]       dec_m1,
    output logic [NP*W-1:0]     taps,
    output logic signed [W-1:0] dout
);
    typedef struct packed {
        logic [LEN-1:0][W-1:0] line;
    } dl_st_t;

    dl_st_t s_d, s_q;
    logic [IW-1:0] step;

    always_comb begin
        s_d = s_q;
        if (adv) begin
            s_d.line[0] = din;
            for (int i = 1; i < LEN; i++) begin
                s_d.line[i] = s_q.line[i-1];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign step = IW'(dec_m1) + IW'(1);

    generate
        for (genvar k = 0; k < NP; k++) begin : g_tap
            assign taps[k*W +: W] = s_q.line[IW'(k) * step];
        end
    endgenerate

    // index wraps to LEN-1 when NP*step equals LEN
    assign dout = s_q.line[IW'(NP) * step - IW'(1)];
endmodule

// File: rtl/symfir_lifo2.sv
module symfir_lifo2 #(
    parameter int W     = 10,
    parameter int DEPTH = 64,
    localparam int NW   = $clog2(DEPTH + 1),
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                step,
    input  logic                swap,
    input  logic signed [W-1:0] wdata,
    output logic signed [W-1:0] rdata
);
    typedef struct packed {
        logic [1:0][DEPTH-1:0][W-1:0] mem;
        logic [1:0][NW-1:0]           cnt;
        logic                         rsel;
    } lifo_st_t;

    lifo_st_t s_d, s_q;
    logic [NW-1:0] rcnt, wcnt;
    logic          wsel;

    always_comb begin
        s_d   = s_q;
        wsel  = ~s_q.rsel;
        rcnt  = s_q.cnt[s_q.rsel];
        wcnt  = s_q.cnt[wsel];
        rdata = (rcnt != '0) ? s_q.mem[s_q.rsel][AW'(rcnt - NW'(1))] : '0;
        if (step) begin
            if (wcnt < NW'(DEPTH)) begin
                s_d.mem[wsel][AW'(wcnt)] = wdata;
                s_d.cnt[wsel]            = wcnt + NW'(1);
            end
            if (rcnt != '0) s_d.cnt[s_q.rsel] = rcnt - NW'(1);
        end
        if (swap) begin
            s_d.rsel          = wsel;
            s_d.cnt[s_q.rsel] = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    AST_LIFO_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.cnt[0] <= NW'(DEPTH)) && (s_q.cnt[1] <= NW'(DEPTH)))
        else $error("lifo count out of range"); // R8
    AST_SWAP_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        swap |=> (s_q.cnt[~s_q.rsel] == '0))
        else $error("new write lifo not empty after swap"); // R8
endmodule

// File: rtl/symfir_mac.sv
module symfir_mac #(
    parameter int SW  = 10,
    parameter int CW  = 10,
    parameter int NP  = 4,
    localparam int PW = SW + 1,
    localparam int MW = PW + CW,
    localparam int OW = MW + $clog2(NP)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NP*SW-1:0]     fwd_taps,
    input  logic [NP*SW-1:0]     rev_taps,
    input  logic [NP*CW-1:0]     coefs,
    input  logic                 fwd_en,
    input  logic                 rev_en,
    output logic signed [OW-1:0] sum_o
);
    typedef struct packed {
        logic signed [OW-1:0] sum;
    } mac_st_t;

    mac_st_t s_d, s_q;
    logic signed [MW-1:0] prod [NP];

    generate
        for (genvar k = 0; k < NP; k++) begin : g_lane
            logic signed [SW-1:0] opa, opb;
            logic signed [PW-1:0] pre;
            logic signed [CW-1:0] cf;
            assign opa     = fwd_en ? $signed(fwd_taps[k*SW +: SW]) : '0;
            assign opb     = rev_en ? $signed(rev_taps[k*SW +: SW]) : '0;
            assign pre     = PW'(opa) + PW'(opb);
            assign cf      = $signed(coefs[k*CW +: CW]);
            assign prod[k] = MW'(pre) * MW'(cf);
        end
    endgenerate

    always_comb begin
        logic signed [OW-1:0] acc;
        acc = '0;
        for (int k = 0; k < NP; k++) begin
            acc = acc + OW'(prod[k]);
        end
        s_d.sum = acc;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign sum_o = s_q.sum;
endmodule

// File: rtl/symfir_cell.sv
module symfir_cell
    import symfir_pkg::*;
#(
    parameter int SW     = SMP_W_DEF,
    parameter int CW     = COEF_W_DEF,
    parameter int NP     = PAIRS_DEF,
    parameter int DMAX   = DEC_MAX_DEF,
    parameter int LDEPTH = NP * DMAX,
    localparam int DW    = $clog2(DMAX),
    localparam int OW    = SW + 1 + CW + $clog2(NP)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic signed [SW-1:0] smp_i,
    input  logic [NP*CW-1:0]     coef_i,
    input  logic                 shift_n_i,
    input  logic                 fwd_n_i,
    input  logic                 rev_n_i,
    input  logic                 xfer_n_i,
    input  logic [DW-1:0]        dec_m1_i,
    output logic signed [OW-1:0] sum_o
);
    typedef struct packed {
        logic [SW-1:0]    smp;
        logic [NP*CW-1:0] coef;
        strobe_t          ctl;
    } in_st_t;

    localparam in_st_t IN_RST = '{smp: '0, coef: '0, ctl: '{default: 1'b1}};

    in_st_t in_d, in_q;
    logic [NP*SW-1:0]     fwd_taps, rev_taps;
    logic signed [SW-1:0] fwd_exit, rev_exit, lifo_out;
    logic                 adv, swap;

    always_comb begin
        in_d.smp         = smp_i;
        in_d.coef        = coef_i;
        in_d.ctl.shift_n = shift_n_i;
        in_d.ctl.fwd_n   = fwd_n_i;
        in_d.ctl.rev_n   = rev_n_i;
        in_d.ctl.xfer_n  = xfer_n_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) in_q <= IN_RST;
        else        in_q <= in_d;
    end

    assign adv  = ~in_q.ctl.shift_n;
    assign swap = ~in_q.ctl.xfer_n;

    symfir_dline #(.W(SW), .NP(NP), .DMAX(DMAX)) u_fwd (
        .clk(clk), .rst_n(rst_n), .adv(adv), .din($signed(in_q.smp)),
        .dec_m1(dec_m1_i), .taps(fwd_taps), .dout(fwd_exit)
    );

    symfir_lifo2 #(.W(SW), .DEPTH(LDEPTH)) u_lifo (
        .clk(clk), .rst_n(rst_n), .step(adv), .swap(swap),
        .wdata(fwd_exit), .rdata(lifo_out)
    );

    symfir_dline #(.W(SW), .NP(NP), .DMAX(DMAX)) u_rev (
        .clk(clk), .rst_n(rst_n), .adv(adv), .din(lifo_out),
        .dec_m1(dec_m1_i), .taps(rev_taps), .dout(rev_exit)
    );

    symfir_mac #(.SW(SW), .CW(CW), .NP(NP)) u_mac (
        .clk(clk), .rst_n(rst_n), .fwd_taps(fwd_taps), .rev_taps(rev_taps),
        .coefs(in_q.coef), .fwd_en(~in_q.ctl.fwd_n), .rev_en(~in_q.ctl.rev_n),
        .sum_o(sum_o)
    );

    AST_HOLD_LINES: assert property (@(posedge clk) disable iff (!rst_n)
        in_q.ctl.shift_n |=> ($stable(fwd_taps) && $stable(rev_taps) && $stable(rev_exit)))
        else $error("delay lines moved without shift"); // R4
    AST_GATED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (in_q.ctl.fwd_n && in_q.ctl.rev_n) |=> (sum_o == '0))
        else $error("sum nonzero with both operands gated"); // R5
endmodule

// File: tb/sim_symfir_cell.sv
module sim_symfir_cell;
    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic signed [9:0]  smp = '0;
    logic [39:0]        coef = '0;
    logic               shift_n = 1'b1, fwd_n = 1'b1, rev_n = 1'b1, xfer_n = 1'b1;
    logic [3:0]         dec = '0;
    logic signed [22:0] sum;
    int nchk = 0, nfail = 0;
    bit done = 1'b0;

    symfir_cell u0 (
        .clk(clk), .rst_n(rst_n), .smp_i(smp), .coef_i(coef),
        .shift_n_i(shift_n), .fwd_n_i(fwd_n), .rev_n_i(rev_n),
        .xfer_n_i(xfer_n), .dec_m1_i(dec), .sum_o(sum)
    );

    always #2 clk = ~clk;

    task automatic check(input string req, input int exp);
        nchk++;
        if (sum !== 23'(exp)) begin
            nfail++;
            $display("FAIL %s got=%0d exp=%0d", req, sum, exp);
        end
    endtask

    task automatic do_reset(input logic [3:0] d);
        @(negedge clk);
        rst_n = 1'b0; dec = d; shift_n = 1'b1; xfer_n = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic set_coefs(input int c0, input int c1, input int c2, input int c3);
        coef = {10'(c3), 10'(c2), 10'(c1), 10'(c0)};
    endtask

    task automatic shift_in(input int x);
        @(negedge clk);
        smp = 10'(x); shift_n = 1'b0;
        @(negedge clk);
        shift_n = 1'b1;
    endtask

    task automatic xfer();
        @(negedge clk);
        xfer_n = 1'b0;
        @(negedge clk);
        xfer_n = 1'b1;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset();
        do_reset(4'd0);
        set_coefs(100, -200, 300, -400); fwd_n = 1'b0; rev_n = 1'b0;
        settle();
        check("R1 after reset", 0);
    endtask

    task automatic t_forward();
        do_reset(4'd0);
        set_coefs(3, -5, 7, 11); fwd_n = 1'b0; rev_n = 1'b1;
        shift_in(10); shift_in(-20); shift_in(30); shift_in(-40);
        settle();
        check("R2 forward pattern a", -300);
        shift_in(100); shift_in(200);
        settle();
        check("R2 forward pattern b", 150);
    endtask

    task automatic t_hold();
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            smp = 10'(i * 37 - 90);
        end
        settle();
        check("R4 hold with shift high", 150);
    endtask

    task automatic t_midreset();
        fwd_n = 1'b0; rev_n = 1'b0;
        do_reset(4'd0);
        settle();
        check("R1 mid-run reset clears lines", 0);
    endtask

    task automatic t_decim();
        do_reset(4'd1);
        set_coefs(3, -5, 7, 11); fwd_n = 1'b0; rev_n = 1'b1;
        for (int i = 1; i <= 8; i++) shift_in(i);
        settle();
        check("R7 decimation 2", 44);
        do_reset(4'd2);
        for (int i = 1; i <= 12; i++) shift_in(i);
        settle();
        check("R7 decimation 3", 66);
    endtask

    task automatic t_lifo();
        do_reset(4'd0);
        set_coefs(3, -5, 7, 11); fwd_n = 1'b1; rev_n = 1'b0;
        shift_in(5); shift_in(-6); shift_in(7); shift_in(-8);
        shift_in(1); shift_in(2); shift_in(3); shift_in(4);
        settle();
        check("R9 empty read lifo gives zero", 0);
        xfer();
        for (int i = 0; i < 4; i++) shift_in(0);
        settle();
        check("R8 reversed readout after swap", 6);
        xfer();
        for (int i = 0; i < 4; i++) shift_in(0);
        settle();
        check("R8 second swap readout", 58);
    endtask

    task automatic t_fullscale();
        do_reset(4'd0);
        set_coefs(-512, -512, -512, -512); fwd_n = 1'b0; rev_n = 1'b0;
        for (int i = 0; i < 8; i++) shift_in(-512);
        xfer();
        for (int i = 0; i < 4; i++) shift_in(-512);
        settle();
        check("R3 full-scale positive", 2097152);
        rev_n = 1'b1;
        settle();
        check("R6 reverse operand gated", 1048576);
        fwd_n = 1'b1; rev_n = 1'b0;
        settle();
        check("R5 forward operand gated", 1048576);
        rev_n = 1'b1;
        settle();
        check("R5 both operands gated", 0);
        fwd_n = 1'b0; rev_n = 1'b0;
        set_coefs(511, 511, 511, 511);
        settle();
        check("R3 full-scale negative", -2093056);
    endtask

    initial begin
        t_reset();
        t_forward();
        t_hold();
        t_midreset();
        t_decim();
        t_lifo();
        t_fullscale();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog expired got=running exp=finished");
            $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
            $finish;
        end
    end
endmodule